// File: doc/BRIEF.md
# Windowed VGA Frame Scanner

The scanner produces the raster timing for a 640x480 display at about 60 frames per second. It works from a pixel clock near 25.175 MHz and advances one pixel per rising edge. A square image window, 256x256 by default, sits centred in the visible area. For each window pixel the block reads one 3-bit colour from an external memory through an address output. The rest of the visible area shows one constant border colour, taken from an input. Everything outside the visible area is driven black.

The image address is a running pixel index inside the window. It moves on the falling clock edge, and only after a window pixel has been shown, so border and blanking time leave it unchanged. The memory data is captured on the next rising edge, which gives the memory half a clock to settle. The colour and sync outputs come from registers. They show the state of the position counters one clock after that position was present. The external memory and the analogue colour network are not part of the block.

Top module: `vga_window_scanner`

## Requirements
- R1: A line lasts H_VIS+H_FP+H_SYNC+H_BP clocks (800 by default) and a frame lasts V_VIS+V_FP+V_SYNC+V_BP lines (525 by default). The falling edges of hsync_n are one line apart and the falling edges of vsync_n are one frame apart.
- R2: hsync_n is low, one clock late, exactly for the columns H_VIS+H_FP up to H_VIS+H_FP+H_SYNC-1 (656 to 751 by default) on every line, and high for all other columns.
- R3: vsync_n is low, one clock late, for every position on lines V_VIS+V_FP up to V_VIS+V_FP+V_SYNC-1 (490 and 491 by default), and high on all other lines.
- R4: red, green and blue are all 0 for every position at column H_VIS or beyond, or at line V_VIS or beyond.
- R5: For a window position, the colour outputs one clock later equal the mem_data value sampled on the rising edge that ends that position. Bit 2 drives red, bit 1 drives green and bit 0 drives blue.
- R6: For a visible position outside the window, the colour outputs one clock later equal border_rgb, with the same bit order as R5.
- R7: mem_addr changes only on falling clock edges. It goes up by one, wrapping at 2^ADDR_W, on the falling edge after each window position. It stays constant across border and blanking positions.
- R8: mem_addr is 0 from the falling edge of the first position of each frame (column 0, line 0). The first window pixel of every frame therefore reads address 0.
- R9: While rst is high, on every rising edge the position goes back to column 0, line 0, the colour outputs go to 0 and both syncs go high. mem_addr goes to 0 on the falling edge.
- R10: The window spans columns (H_VIS-WIN_W)/2 up to that value plus WIN_W-1 (192 to 447 by default). It spans lines (V_VIS-WIN_H)/2 up to that value plus WIN_H-1 (112 to 367 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, one pixel per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| border_rgb | input | 3 | Border colour {red, green, blue} |
| mem_data | input | 3 | Colour read from memory at mem_addr, {red, green, blue} |
| mem_addr | output | ADDR_W | Image memory address, updated on falling edges |
| red | output | 1 | Registered red output |
| green | output | 1 | Registered green output |
| blue | output | 1 | Registered blue output |
| hsync_n | output | 1 | Registered horizontal sync, active low |
| vsync_n | output | 1 | Registered vertical sync, active low |

## Verification
The bench does not use the default timing, which would take more than 400,000 clocks per frame. It uses a shrunk raster: a 24-column line with porches of 2 and 3 and a 3-clock sync, and 16 visible lines with 1-line porches and a 2-line sync. The window is 8x8 and ADDR_W is 6. With this window the 64-entry address space is used up exactly, so every frame ends with the address wrapping back to zero. It also reaches both sync pulses, all four window edges, several border colours and a reset in mid-frame, each many times within a few thousand clocks.

// File: rtl/vga_scan_pkg.sv
package vga_scan_pkg;

  typedef logic [2:0] rgb3_t;

  function automatic int unsigned total_of(input int unsigned vis, input int unsigned fp,
                                           input int unsigned sy, input int unsigned bp);
    return vis + fp + sy + bp;
  endfunction

  function automatic int unsigned centre_of(input int unsigned span, input int unsigned win);
    return (span - win) / 2;
  endfunction

endpackage

// File: rtl/vga_axis_counter.sv
module vga_axis_counter #(
  parameter int unsigned VIS  = 640,
  parameter int unsigned FP   = 16,
  parameter int unsigned SYNC = 96,
  parameter int unsigned BP   = 48,
  parameter int unsigned WIN  = 256
) (
  input  logic                                               clk,
  input  logic                                               rst,
  input  logic                                               step,
  output logic [$clog2(vga_scan_pkg::total_of(VIS,FP,SYNC,BP))-1:0] pos,
  output logic                                               wrap,
  output logic                                               vis,
  output logic                                               sync_act,
  output logic                                               in_win
);
  import vga_scan_pkg::*;

  localparam int unsigned TOTAL = total_of(VIS, FP, SYNC, BP);
  localparam int unsigned CW    = $clog2(TOTAL);
  localparam int unsigned W0    = centre_of(VIS, WIN);
  localparam logic [CW-1:0] LAST    = CW'(TOTAL - 1);
  localparam logic [CW-1:0] VIS_END = CW'(VIS);
  localparam logic [CW-1:0] SY_BEG  = CW'(VIS + FP);
  localparam logic [CW-1:0] SY_END  = CW'(VIS + FP + SYNC);
  localparam logic [CW-1:0] WIN_BEG = CW'(W0);
  localparam logic [CW-1:0] WIN_END = CW'(W0 + WIN);

  logic at_last;

  assign at_last = (pos == LAST);
  assign wrap    = step && at_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
    end else if (step) begin
      pos <= at_last ? '0 : pos + 1'b1;
    end
  end

  assign vis      = (pos < VIS_END);
  assign sync_act = (pos >= SY_BEG) && (pos < SY_END);
  assign in_win   = (pos >= WIN_BEG) && (pos < WIN_END);

endmodule

// File: rtl/vga_window_addr.sv
module vga_window_addr #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              in_win,
  output logic [ADDR_W-1:0] addr
);
  logic prev_win;

  always_ff @(negedge clk) begin
    if (rst) begin
      addr     <= '0;
      prev_win <= 1'b0;
    end else begin
      if (frame_start) begin
        addr <= '0;
      end else if (prev_win) begin
        addr <= addr + 1'b1;
      end
      prev_win <= in_win;
    end
  end

endmodule

// File: rtl/vga_pixel_out.sv
module vga_pixel_out (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  vis,
  input  logic                  in_win,
  input  logic                  hs_act,
  input  logic                  vs_act,
  input  vga_scan_pkg::rgb3_t   mem_data,
  input  vga_scan_pkg::rgb3_t   border_rgb,
  output vga_scan_pkg::rgb3_t   rgb_q,
  output logic                  hsync_n,
  output logic                  vsync_n
);
  import vga_scan_pkg::*;

  rgb3_t rgb_next;

  always_comb begin
    if (!vis) begin
      rgb_next = '0;
    end else if (in_win) begin
      rgb_next = mem_data;
    end else begin
      rgb_next = border_rgb;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rgb_q   <= '0;
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
    end else begin
      rgb_q   <= rgb_next;
      hsync_n <= !hs_act;
      vsync_n <= !vs_act;
    end
  end

endmodule

// File: rtl/vga_window_scanner.sv
module vga_window_scanner #(
  parameter int unsigned H_VIS  = 640,
  parameter int unsigned H_FP   = 16,
  parameter int unsigned H_SYNC = 96,
  parameter int unsigned H_BP   = 48,
  parameter int unsigned V_VIS  = 480,
  parameter int unsigned V_FP   = 10,
  parameter int unsigned V_SYNC = 2,
  parameter int unsigned V_BP   = 33,
  parameter int unsigned WIN_W  = 256,
  parameter int unsigned WIN_H  = 256,
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        border_rgb,
  input  logic [2:0]        mem_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              red,
  output logic              green,
  output logic              blue,
  output logic              hsync_n,
  output logic              vsync_n
);
  import vga_scan_pkg::*;

  localparam int unsigned H_TOTAL = total_of(H_VIS, H_FP, H_SYNC, H_BP);
  localparam int unsigned V_TOTAL = total_of(V_VIS, V_FP, V_SYNC, V_BP);
  localparam int unsigned HW      = $clog2(H_TOTAL);
  localparam int unsigned VW      = $clog2(V_TOTAL);

  logic [HW-1:0] h_pos;
  logic [VW-1:0] v_pos;
  logic          h_wrap, v_wrap;
  logic          h_vis, v_vis, h_sync, v_sync, h_win, v_win;
  logic          frame_start;
  rgb3_t         rgb_q;

  vga_axis_counter #(
    .VIS(H_VIS), .FP(H_FP), .SYNC(H_SYNC), .BP(H_BP), .WIN(WIN_W)
  ) h_axis_i (
    .clk(clk), .rst(rst), .step(1'b1),
    .pos(h_pos), .wrap(h_wrap), .vis(h_vis), .sync_act(h_sync), .in_win(h_win)
  );

  vga_axis_counter #(
    .VIS(V_VIS), .FP(V_FP), .SYNC(V_SYNC), .BP(V_BP), .WIN(WIN_H)
  ) v_axis_i (
    .clk(clk), .rst(rst), .step(h_wrap),
    .pos(v_pos), .wrap(v_wrap), .vis(v_vis), .sync_act(v_sync), .in_win(v_win)
  );

  assign frame_start = (h_pos == '0) && (v_pos == '0);

  vga_window_addr #(
    .ADDR_W(ADDR_W)
  ) addr_i (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .in_win(h_win && v_win), .addr(mem_addr)
  );

  vga_pixel_out out_i (
    .clk(clk), .rst(rst),
    .vis(h_vis && v_vis), .in_win(h_win && v_win),
    .hs_act(h_sync), .vs_act(v_sync),
    .mem_data(mem_data), .border_rgb(border_rgb),
    .rgb_q(rgb_q), .hsync_n(hsync_n), .vsync_n(vsync_n)
  );

  assign red   = rgb_q[2];
  assign green = rgb_q[1];
  assign blue  = rgb_q[0];

endmodule

// File: rtl/vga_window_scanner_chk.sv
module vga_window_scanner_chk #(
  parameter int unsigned H_TOTAL = 800,
  parameter int unsigned V_TOTAL = 525,
  parameter int unsigned H_VIS   = 640,
  parameter int unsigned V_VIS   = 480,
  parameter int unsigned ADDR_W  = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic [$clog2(H_TOTAL)-1:0] h_pos,
  input logic [$clog2(V_TOTAL)-1:0] v_pos,
  input logic [ADDR_W-1:0]          mem_addr,
  input logic                       red,
  input logic                       green,
  input logic                       blue,
  input logic                       hsync_n,
  input logic                       vsync_n
);
  localparam int unsigned HW = $clog2(H_TOTAL);
  localparam int unsigned VW = $clog2(V_TOTAL);

  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (h_pos == HW'(H_TOTAL - 1)) |=> (h_pos == '0)); // R1

  AST_HSYNC_IDLE_VIS: assert property (@(posedge clk) disable iff (rst)
    (h_pos < HW'(H_VIS)) |=> hsync_n); // R2

  AST_VSYNC_IDLE_VIS: assert property (@(posedge clk) disable iff (rst)
    (v_pos < VW'(V_VIS)) |=> vsync_n); // R3

  AST_BLANK_RGB: assert property (@(posedge clk) disable iff (rst)
    ((h_pos >= HW'(H_VIS)) || (v_pos >= VW'(V_VIS))) |=> !(red || green || blue)); // R4

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (mem_addr == $past(mem_addr)) || (mem_addr == $past(mem_addr) + 1'b1)
    || (mem_addr == '0)); // R7

  AST_FRAME_ADDR0: assert property (@(posedge clk) disable iff (rst)
    ((h_pos == HW'(1)) && (v_pos == '0)) |-> (mem_addr == '0)); // R8

  AST_RESET_OUT: assert property (@(posedge clk)
    rst |=> (hsync_n && vsync_n && !(red || green || blue))); // R9

endmodule

bind vga_window_scanner vga_window_scanner_chk #(
  .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .H_VIS(H_VIS), .V_VIS(V_VIS), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst(rst), .h_pos(h_pos), .v_pos(v_pos), .mem_addr(mem_addr),
  .red(red), .green(green), .blue(blue), .hsync_n(hsync_n), .vsync_n(vsync_n)
);

// File: tb/vga_window_scanner_tb_top.sv
module vga_window_scanner_tb_top;
  localparam int H_VIS = 24, H_FP = 2, H_SYNC = 3, H_BP = 3;
  localparam int V_VIS = 16, V_FP = 1, V_SYNC = 2, V_BP = 1;
  localparam int WIN_W = 8, WIN_H = 8, ADDR_W = 6;
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int X0 = (H_VIS - WIN_W) / 2;
  localparam int Y0 = (V_VIS - WIN_H) / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] border_rgb = 3'b100;
  logic [2:0] mem_data;
  logic [ADDR_W-1:0] mem_addr;
  logic red, green, blue, hsync_n, vsync_n;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  function automatic logic [2:0] memf(input logic [ADDR_W-1:0] a);
    return a[2:0] ^ a[5:3] ^ 3'(a[5]);
  endfunction

  assign mem_data = memf(mem_addr);

  vga_window_scanner #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .WIN_W(WIN_W), .WIN_H(WIN_H), .ADDR_W(ADDR_W)
  ) dut_i (
    .clk(clk), .rst(rst), .border_rgb(border_rgb), .mem_data(mem_data),
    .mem_addr(mem_addr), .red(red), .green(green), .blue(blue),
    .hsync_n(hsync_n), .vsync_n(vsync_n)
  );

  int mh, mv, m_addr, cyc, last_hfall, last_vfall;
  bit m_was, prev_hs, prev_vs;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at h=%0d v=%0d: actual=%0d expected=%0d", req, mh, mv, act, exp);
    end
  endtask

  function automatic bit inwin(input int h, input int v);
    return (h >= X0) && (h < X0 + WIN_W) && (v >= Y0) && (v < Y0 + WIN_H);
  endfunction

  task automatic restart_model();
    mh = 0; mv = 0; m_addr = 0; m_was = 0;
    last_hfall = -1; last_vfall = -1; prev_hs = 1; prev_vs = 1;
  endtask

  task automatic run_cycle();
    logic [2:0] e_rgb;
    bit e_hs, e_vs, vis;
    @(negedge clk);
    if (mh == 0 && mv == 0) m_addr = 0;
    else if (m_was) m_addr = (m_addr + 1) % (1 << ADDR_W);
    m_was = inwin(mh, mv);
    #1;
    if (mh == 0 && mv == 0)
      chk(mem_addr == ADDR_W'(m_addr), "R8 frame address", int'(mem_addr), m_addr);
    else
      chk(mem_addr == ADDR_W'(m_addr), "R7 address", int'(mem_addr), m_addr);
    vis = (mh < H_VIS) && (mv < V_VIS);
    e_rgb = !vis ? 3'b000 : inwin(mh, mv) ? memf(ADDR_W'(m_addr)) : border_rgb;
    e_hs = !((mh >= H_VIS + H_FP) && (mh < H_VIS + H_FP + H_SYNC));
    e_vs = !((mv >= V_VIS + V_FP) && (mv < V_VIS + V_FP + V_SYNC));
    @(posedge clk);
    #1;
    cyc++;
    if (!vis)
      chk({red, green, blue} == e_rgb, "R4 blank", int'({red, green, blue}), int'(e_rgb));
    else if (inwin(mh, mv) && (mh == X0 || mh == X0 + WIN_W - 1 || mv == Y0 || mv == Y0 + WIN_H - 1))
      chk({red, green, blue} == e_rgb, "R10 window edge", int'({red, green, blue}), int'(e_rgb));
    else if (inwin(mh, mv))
      chk({red, green, blue} == e_rgb, "R5 window pixel", int'({red, green, blue}), int'(e_rgb));
    else
      chk({red, green, blue} == e_rgb, "R6 border", int'({red, green, blue}), int'(e_rgb));
    chk(hsync_n == e_hs, "R2 hsync", int'(hsync_n), int'(e_hs));
    chk(vsync_n == e_vs, "R3 vsync", int'(vsync_n), int'(e_vs));
    if (prev_hs && !hsync_n) begin
      if (last_hfall >= 0) chk(cyc - last_hfall == H_TOT, "R1 line period", cyc - last_hfall, H_TOT);
      last_hfall = cyc;
    end
    if (prev_vs && !vsync_n) begin
      if (last_vfall >= 0)
        chk(cyc - last_vfall == H_TOT * V_TOT, "R1 frame period", cyc - last_vfall, H_TOT * V_TOT);
      last_vfall = cyc;
    end
    prev_hs = hsync_n; prev_vs = vsync_n;
    mh++;
    if (mh == H_TOT) begin
      mh = 0; mv++;
      if (mv == V_TOT) mv = 0;
    end
  endtask

  task automatic reset_phase(input int n);
    rst = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      chk({red, green, blue} == 3'b000, "R9 reset rgb", int'({red, green, blue}), 0);
      chk(hsync_n && vsync_n, "R9 reset syncs", int'({hsync_n, vsync_n}), 3);
      @(negedge clk); #1;
      chk(mem_addr == '0, "R9 reset address", int'(mem_addr), 0);
      @(posedge clk); #1;
    end
    rst = 1'b0;
    restart_model();
  endtask

  task automatic run_frames(input int nf, input logic [2:0] first_border);
    logic [2:0] b;
    b = first_border;
    for (int f = 0; f < nf * H_TOT * V_TOT; f++) begin
      if (mh == 0 && mv == 0) begin
        border_rgb = b;
        b = b + 3'd3;
      end
      run_cycle();
    end
  endtask

  initial begin
    cyc = 0;
    restart_model();
    reset_phase(3);
    run_frames(3, 3'b100);
    for (int k = 0; k < 300; k++) run_cycle();
    reset_phase(2);
    run_frames(2, 3'b001);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule